// File: doc/BRIEF.md
# RMII Receive Dibit-to-Byte Assembler

This block sits on the MAC side of a reduced media-independent interface at 100 Mbit/s. On every edge of the single reference clock it samples the carrier/data-valid line, the two receive data bits and the receive-error line. It throws away the zero dibits that the PHY presents before decoding settles. It then locks onto the preamble and the start-of-frame delimiter, and after that it packs each group of four dibits into one byte, least significant pair first.

The output is a byte stream. A one-cycle strobe marks each finished byte, and the first byte of a frame carries a start flag. When the carrier drops, the block gives a one-cycle end-of-frame pulse. That pulse carries two flags: a sticky receive-error flag, and an alignment flag for frames that stop partway through a byte. A frame whose carrier drops before the delimiter is dropped without any output. The block relies on the carrier line staying high through the last data dibit and falling on the next clock edge.

Top module: `rmii_rx_assembler`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `byte_valid`, `sof`, `eof`, `rx_err` and `align_err` are all 0.
- R2: After `crs_dv` goes high, every dibit before the first `01` is ignored, whatever its value. This covers the leading `00` dibits and also stray `10` or `11` dibits.
- R3: After one or more `01` dibits, a `11` dibit ends the delimiter. The next dibit becomes bits [1:0] of the first byte. A `00` or `10` seen inside the preamble sends the block back to hunting for `01`.
- R4: Each group of four data dibits forms one byte, with dibit k placed in bits [2k+1:2k]. `rx_byte` is valid and `byte_valid` is high for exactly one cycle, on the cycle after the clock edge that samples the fourth dibit.
- R5: `sof` is high together with `byte_valid` for the first byte of a frame only.
- R6: When a clock edge samples `crs_dv` low after the delimiter, `eof` is high for exactly the next cycle. `eof` and `byte_valid` are never high in the same cycle.
- R7: `align_err` is high with `eof` when the number of data dibits is not a multiple of four. The trailing partial byte is never emitted.
- R8: `rx_err` is high with `eof` if `rx_er` was sampled high on any edge with `crs_dv` high since the carrier rose. This includes the edge that samples the last dibit. The flag is cleared when the next carrier rises.
- R9: If `crs_dv` falls before the delimiter has been seen, no byte, `sof` or `eof` is produced for that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; all inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| crs_dv | input | 1 | Carrier sense / receive data valid from the PHY |
| rxd | input | 2 | Receive dibit |
| rx_er | input | 1 | Receive error from the PHY |
| rx_byte | output | 8 | Assembled byte, valid while `byte_valid` is high |
| byte_valid | output | 1 | One-cycle strobe for each finished byte |
| sof | output | 1 | Marks the first byte of a frame |
| eof | output | 1 | One-cycle end-of-frame pulse |
| rx_err | output | 1 | Receive error seen in this frame, valid with `eof` |
| align_err | output | 1 | Frame ended partway through a byte, valid with `eof` |

## Verification
Two events can land on the same clock edge. One is the edge that samples the fourth dibit of the final byte, which completes that byte. The other is an `rx_er` assertion, which must be latched by the sticky error flag on that same edge. The bench provokes this by raising `rx_er` exactly on that last data dibit and then dropping the carrier on the next dibit slot. It judges the result by three checks: the byte still arrives intact one cycle later, `eof` follows one cycle after that, and `rx_err` is high with it. A following clean frame must then show `rx_err` low, which proves the flag was cleared when the new carrier rose.

// File: rtl/rmii_rx_pkg.sv
package rmii_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_HUNT = 2'd1,
    RX_PRE  = 2'd2,
    RX_DATA = 2'd3
  } rx_state_e;

  localparam logic [1:0] DIBIT_PREAMBLE = 2'b01;
  localparam logic [1:0] DIBIT_SFD_TAIL = 2'b11;

  function automatic logic is_preamble(input logic [1:0] d);
    return d == DIBIT_PREAMBLE;
  endfunction

  function automatic logic is_sfd_tail(input logic [1:0] d);
    return d == DIBIT_SFD_TAIL;
  endfunction

endpackage

// File: rtl/rmii_rx_framer.sv
module rmii_rx_framer
  import rmii_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crs_dv,
  input  logic [1:0] rxd,
  output logic       frame_start,
  output logic       sfd_hit,
  output logic       dibit_en,
  output logic       frame_end
);

  rx_state_e st_q, st_d;

  always_comb begin
    st_d        = st_q;
    frame_start = 1'b0;
    sfd_hit     = 1'b0;
    dibit_en    = 1'b0;
    frame_end   = 1'b0;
    unique case (st_q)
      RX_IDLE: begin
        if (crs_dv) begin
          frame_start = 1'b1;
          st_d = is_preamble(rxd) ? RX_PRE : RX_HUNT;
        end
      end
      RX_HUNT: begin
        if (!crs_dv)               st_d = RX_IDLE;
        else if (is_preamble(rxd)) st_d = RX_PRE;
      end
      RX_PRE: begin
        if (!crs_dv) begin
          st_d = RX_IDLE;
        end else if (is_sfd_tail(rxd)) begin
          sfd_hit = 1'b1;
          st_d    = RX_DATA;
        end else if (!is_preamble(rxd)) begin
          st_d = RX_HUNT;
        end
      end
      RX_DATA: begin
        if (!crs_dv) begin
          frame_end = 1'b1;
          st_d      = RX_IDLE;
        end else begin
          dibit_en = 1'b1;
        end
      end
      default: st_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= RX_IDLE;
    else        st_q <= st_d;
  end

  // R9
  end_needs_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |-> $past(st_d == RX_DATA));

  // R3
  data_follows_sfd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sfd_hit |=> (dibit_en || frame_end));

endmodule

// File: rtl/rmii_rx_packer.sv
module rmii_rx_packer #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        rxd,
  input  logic              sfd_hit,
  input  logic              dibit_en,
  output logic [BYTE_W-1:0] byte_q,
  output logic              byte_valid,
  output logic              sof,
  output logic              partial
);

  localparam int DPB   = BYTE_W / 2;
  localparam int CNT_W = $clog2(DPB);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(DPB - 1);

  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] acc_q;
  logic              first_q;
  logic              byte_done;
  logic [BYTE_W-1:0] acc_next;

  function automatic logic [BYTE_W-1:0] place_dibit(
    input logic [BYTE_W-1:0] acc,
    input logic [CNT_W-1:0]  slot,
    input logic [1:0]        d
  );
    logic [BYTE_W-1:0] r;
    r = acc;
    r[{slot, 1'b0} +: 2] = d;
    return r;
  endfunction

  assign byte_done = dibit_en && (cnt_q == LAST_SLOT);
  assign acc_next  = place_dibit(acc_q, cnt_q, rxd);
  assign partial   = (cnt_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q      <= '0;
      acc_q      <= '0;
      first_q    <= 1'b0;
      byte_q     <= '0;
      byte_valid <= 1'b0;
      sof        <= 1'b0;
    end else begin
      byte_valid <= 1'b0;
      sof        <= 1'b0;
      if (sfd_hit) begin
        cnt_q   <= '0;
        acc_q   <= '0;
        first_q <= 1'b1;
      end else if (dibit_en) begin
        acc_q <= acc_next;
        if (byte_done) begin
          byte_q     <= acc_next;
          byte_valid <= 1'b1;
          sof        <= first_q;
          first_q    <= 1'b0;
          cnt_q      <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  // R4
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

  // R7
  partial_tracks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dibit_en && !byte_done && !sfd_hit) |=> partial);

endmodule

// File: rtl/rmii_rx_errtrack.sv
module rmii_rx_errtrack (
  input  logic clk,
  input  logic rst_n,
  input  logic crs_dv,
  input  logic rx_er,
  input  logic frame_start,
  output logic err_sticky
);

  always_ff @(posedge clk) begin
    if (!rst_n)                err_sticky <= 1'b0;
    else if (frame_start)      err_sticky <= rx_er;
    else if (crs_dv && rx_er)  err_sticky <= 1'b1;
  end

  // R8
  err_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && !rx_er) |=> !err_sticky);

  // R8
  err_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_sticky && !frame_start) |=> err_sticky);

endmodule

// File: rtl/rmii_rx_assembler.sv
module rmii_rx_assembler #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crs_dv,
  input  logic [1:0]        rxd,
  input  logic              rx_er,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              byte_valid,
  output logic              sof,
  output logic              eof,
  output logic              rx_err,
  output logic              align_err
);

  logic frame_start;
  logic sfd_hit;
  logic dibit_en;
  logic frame_end;
  logic partial;
  logic err_sticky;

  rmii_rx_framer u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .crs_dv      (crs_dv),
    .rxd         (rxd),
    .frame_start (frame_start),
    .sfd_hit     (sfd_hit),
    .dibit_en    (dibit_en),
    .frame_end   (frame_end)
  );

  rmii_rx_packer #(.BYTE_W(BYTE_W)) u_packer (
    .clk        (clk),
    .rst_n      (rst_n),
    .rxd        (rxd),
    .sfd_hit    (sfd_hit),
    .dibit_en   (dibit_en),
    .byte_q     (rx_byte),
    .byte_valid (byte_valid),
    .sof        (sof),
    .partial    (partial)
  );

  rmii_rx_errtrack u_err (
    .clk         (clk),
    .rst_n       (rst_n),
    .crs_dv      (crs_dv),
    .rx_er       (rx_er),
    .frame_start (frame_start),
    .err_sticky  (err_sticky)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eof       <= 1'b0;
      rx_err    <= 1'b0;
      align_err <= 1'b0;
    end else begin
      eof       <= frame_end;
      rx_err    <= frame_end && err_sticky;
      align_err <= frame_end && partial;
    end
  end

  // R6
  eof_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof |=> !eof);

  // R6
  eof_byte_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(eof && byte_valid));

  // R5
  sof_with_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |-> byte_valid);

  // R7
  align_with_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |-> eof);

  // R8
  err_with_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_err |-> eof);

endmodule

// File: tb/rmii_rx_assembler_test.sv
`timescale 1ns/1ps
module rmii_rx_assembler_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       crs_dv = 1'b0;
  logic [1:0] rxd = 2'b00;
  logic       rx_er = 1'b0;
  logic [7:0] rx_byte;
  logic       byte_valid, sof, eof, rx_err, align_err;

  int tests = 0;
  int fails = 0;
  int cyc = 0;

  // monitor records
  logic [7:0] got_b [16];
  int         got_c [16];
  bit         got_s [16];
  int         n_got = 0;
  int         n_eof = 0;
  int         eof_c = 0;
  bit         eof_err = 0;
  bit         eof_aln = 0;

  // stimulus
  logic [7:0] tx [8];
  int         exp_c [8];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rmii_rx_assembler uut (
    .clk(clk), .rst_n(rst_n), .crs_dv(crs_dv), .rxd(rxd), .rx_er(rx_er),
    .rx_byte(rx_byte), .byte_valid(byte_valid), .sof(sof), .eof(eof),
    .rx_err(rx_err), .align_err(align_err)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_valid && n_got < 16) begin
        got_b[n_got] = rx_byte;
        got_c[n_got] = cyc;
        got_s[n_got] = sof;
        n_got = n_got + 1;
      end
      if (eof) begin
        n_eof   = n_eof + 1;
        eof_c   = cyc;
        eof_err = rx_err;
        eof_aln = align_err;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic [1:0] d, input logic e);
    @(posedge clk);
    #1;
    crs_dv = c;
    rxd    = d;
    rx_er  = e;
  endtask

  task automatic clear_mon();
    n_got = 0; n_eof = 0; eof_err = 0; eof_aln = 0;
  endtask

  // junk: 0 none, 1 stray dibits while hunting, 2 broken preamble
  task automatic frame(input int lead, input int nbytes, input int tail,
                       input int er_at, input int junk, input string tag);
    int last;
    clear_mon();
    for (int i = 0; i < lead; i++) drive(1'b1, 2'b00, 1'b0);
    if (junk == 1) begin
      drive(1'b1, 2'b10, 1'b0); drive(1'b1, 2'b11, 1'b0); drive(1'b1, 2'b10, 1'b0);
    end else if (junk == 2) begin
      drive(1'b1, 2'b01, 1'b0); drive(1'b1, 2'b01, 1'b0); drive(1'b1, 2'b10, 1'b0);
      drive(1'b1, 2'b00, 1'b0);
    end
    for (int i = 0; i < 31; i++) drive(1'b1, 2'b01, 1'b0);
    drive(1'b1, 2'b11, 1'b0);
    for (int i = 0; i < nbytes; i++) begin
      for (int k = 0; k < 4; k++) begin
        drive(1'b1, 2'((tx[i] >> (2 * k)) & 8'h3), (i * 4 + k) == er_at);
        if (k == 3) exp_c[i] = cyc + 1;
      end
    end
    for (int i = 0; i < tail; i++) drive(1'b1, 2'b10, (nbytes * 4 + i) == er_at);
    drive(1'b0, 2'b00, 1'b0);
    last = cyc + 1;
    repeat (4) drive(1'b0, 2'b00, 1'b0);
    chk(n_got == nbytes, {tag, " R4/R7 byte count"}, n_got, nbytes);
    for (int i = 0; i < nbytes && i < n_got; i++) begin
      chk(got_b[i] == tx[i], {tag, " R3/R4 byte value"}, got_b[i], tx[i]);
      chk(got_c[i] == exp_c[i], {tag, " R4 byte timing"}, got_c[i], exp_c[i]);
      chk(got_s[i] == (i == 0), {tag, " R5 sof"}, got_s[i], i == 0);
    end
    chk(n_eof == 1, {tag, " R6 eof count"}, n_eof, 1);
    chk(eof_c == last, {tag, " R6 eof timing"}, eof_c, last);
    chk(eof_aln == ((tail % 4) != 0), {tag, " R7 align_err"}, eof_aln, (tail % 4) != 0);
    chk(eof_err == (er_at >= 0), {tag, " R8 rx_err"}, eof_err, er_at >= 0);
  endtask

  task automatic t_reset();
    chk(!byte_valid && !sof && !eof && !rx_err && !align_err, "R1 outputs in reset",
        {byte_valid, sof, eof, rx_err, align_err}, 0);
    @(posedge clk); #1; rst_n = 1'b1;
    @(negedge clk);
    chk(!byte_valid && !sof && !eof && !rx_err && !align_err, "R1 outputs after reset",
        {byte_valid, sof, eof, rx_err, align_err}, 0);
  endtask

  task automatic t_abort();
    clear_mon();
    for (int i = 0; i < 3; i++) drive(1'b1, 2'b00, 1'b0);
    for (int i = 0; i < 10; i++) drive(1'b1, 2'b01, 1'b0);
    repeat (5) drive(1'b0, 2'b00, 1'b0);
    chk(n_got == 0, "R9 no byte before sfd", n_got, 0);
    chk(n_eof == 0, "R9 no eof before sfd", n_eof, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    repeat (2) drive(1'b0, 2'b00, 1'b0);

    tx[0] = 8'hA5; tx[1] = 8'h3C; tx[2] = 8'h0F; tx[3] = 8'hF0;
    frame(3, 4, 0, -1, 0, "basic R2");

    tx[0] = 8'h12; tx[1] = 8'hD5; tx[2] = 8'h55;
    frame(0, 3, 0, 5, 0, "error mid R8");

    tx[0] = 8'h81; tx[1] = 8'h7E;
    frame(2, 2, 0, -1, 0, "error cleared R8");

    tx[0] = 8'hC3; tx[1] = 8'h96;
    frame(1, 2, 2, -1, 0, "partial byte R7");

    tx[0] = 8'h5A; tx[1] = 8'hE7;
    frame(0, 2, 0, 7, 0, "error on last dibit R8");

    t_abort();

    tx[0] = 8'h01; tx[1] = 8'h80;
    frame(2, 2, 0, -1, 1, "hunt junk R2");

    tx[0] = 8'hFF; tx[1] = 8'h00;
    frame(1, 2, 0, -1, 2, "broken preamble R3");

    frame(1, 0, 0, -1, 0, "empty frame R6");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule